// File: doc/BRIEF.md
# Hash-Chained Measurement Register Bank

This block holds a small set of 160-bit measurement registers whose contents can only move forward through a hash chain. An extend command takes a register's present value, appends a 160-bit measurement, and replaces the register with the SHA-1 digest of that 320-bit message. No command can load a chosen value. As a result, the final contents record the whole sequence of measurements that produced them. A boot chain uses the bank by measuring each stage before handing control to it.

The bank has two kinds of register. Static entries start from all zeros at power-on and can only be extended after that. Dynamic entries start from all ones at power-on, and software may later clear them to all zeros. Because the two start values differ, an observer can tell a fresh boot apart from a later clear. The block contains its own single-block SHA-1 engine, which runs one round per clock. It also has a one-command-per-cycle interface with a busy flag, a done pulse, a refusal pulse and an error pulse.

Top module: `mreg_bank`

## Requirements
- R1: After an extend of register i with measurement m, register i holds SHA-1 of the 512-bit block {old value, m, a single 1 bit, 127 zero bits, the 64-bit length 320}, with the old value in the most significant position.
- R2: The command code is 2 bits: 00 extend, 01 read, 10 clear, 11 no operation. No code writes a supplied value, and code 11 changes no register and raises no output pulse.
- R3: After power-on reset, registers 0 to 3 (static) read as all zeros.
- R4: After power-on reset, registers 4 to 7 (dynamic) read as all ones.
- R5: A clear command (code 10) aimed at a dynamic register sets it to all zeros and raises no error.
- R6: A clear command aimed at a static register leaves it unchanged and drives `err` high for exactly one cycle, in the cycle after the command.
- R7: A read command (code 01) accepted in cycle t drives `rd_valid` high in cycle t+1, with `rd_data` equal to the selected register. `rd_valid` is low otherwise.
- R8: When an extend is accepted in cycle t, `busy` is high from cycle t+1 for exactly 81 cycles. `done` is high for one cycle, in the first cycle in which `busy` is low again, and the register already holds the new value in that cycle.
- R9: A command presented while `busy` is high is refused. `rej` goes high in the next cycle, no read data is returned, and no register changes.
- R10: Repeated extends chain: each one uses the result of the previous one as its old value. A dynamic register extended after a clear starts from zeros, not from ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code: 00 extend, 01 read, 10 clear, 11 no-op |
| cmd_idx | input | 3 | Target register index |
| cmd_meas | input | 160 | Measurement for extend |
| busy | output | 1 | Hash in progress; commands are refused |
| done | output | 1 | One-cycle pulse: extend result stored |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 160 | Register value returned by a read |
| err | output | 1 | One-cycle pulse: clear aimed at a static register |
| rej | output | 1 | One-cycle pulse: command refused while busy |

## Verification
The hardest case to reach from the ports is a command arriving in the middle of an 81-cycle hash. A refused extend, read or clear must leave no trace, either in the running digest or in the target registers. The stimulus counts busy cycles from the moment the extend is accepted and injects an extend, a read and a clear on three consecutive cycles deep inside the round sequence. It then confirms the refusal pulses, checks that the interrupted extend still finishes on the 81st cycle, and reads back every register involved. A static register is extended before it receives a clear, so that an incorrectly accepted clear would change a visible non-zero value.

// File: rtl/mreg_pkg.sv
package mreg_pkg;

  localparam int DIG_W = 160;
  localparam int BLK_W = 512;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_EXTEND = 2'b00,
    OP_READ   = 2'b01,
    OP_CLEAR  = 2'b10,
    OP_NONE   = 2'b11
  } op_e;

  localparam logic [DIG_W-1:0] SHA_IV =
    160'h67452301_EFCDAB89_98BADCFE_10325476_C3D2E1F0;

endpackage

// File: rtl/mreg_sha1.sv
module mreg_sha1
  import mreg_pkg::*;
#(
  parameter int ROUNDS = 80,
  localparam int CNT_W = $clog2(ROUNDS + 1),
  localparam int PAD_ZEROS = BLK_W - 2 * DIG_W - 65
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIG_W-1:0] chain,
  input  logic [DIG_W-1:0] meas,
  output logic             busy,
  output logic             fin,
  output logic [DIG_W-1:0] digest
);

  localparam logic [63:0] MSG_LEN = 64'(2 * DIG_W);

  logic [WORD_W-1:0] va, vb, vc, vd, ve;
  logic [WORD_W-1:0] win [16];
  logic [CNT_W-1:0]  rnd;
  logic [BLK_W-1:0]  blk;
  logic [WORD_W-1:0] f_val, k_val, t_val, w_next;

  assign blk = {chain, meas, 1'b1, {PAD_ZEROS{1'b0}}, MSG_LEN};

  always_comb begin
    if (rnd < CNT_W'(20)) begin
      f_val = (vb & vc) | (~vb & vd);
      k_val = 32'h5A827999;
    end else if (rnd < CNT_W'(40)) begin
      f_val = vb ^ vc ^ vd;
      k_val = 32'h6ED9EBA1;
    end else if (rnd < CNT_W'(60)) begin
      f_val = (vb & vc) | (vb & vd) | (vc & vd);
      k_val = 32'h8F1BBCDC;
    end else begin
      f_val = vb ^ vc ^ vd;
      k_val = 32'hCA62C1D6;
    end
    t_val  = {va[26:0], va[31:27]} + f_val + ve + k_val + win[0];
    w_next = win[13] ^ win[8] ^ win[2] ^ win[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      rnd  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      rnd  <= '0;
      {va, vb, vc, vd, ve} <= SHA_IV;
      for (int i = 0; i < 16; i++) win[i] <= blk[BLK_W-1-WORD_W*i -: WORD_W];
    end else if (busy) begin
      if (rnd == CNT_W'(ROUNDS)) begin
        busy <= 1'b0;
      end else begin
        va  <= t_val;
        vb  <= va;
        vc  <= {vb[1:0], vb[31:2]};
        vd  <= vc;
        ve  <= vd;
        for (int i = 0; i < 15; i++) win[i] <= win[i+1];
        win[15] <= {w_next[30:0], w_next[31]};
        rnd <= rnd + 1'b1;
      end
    end
  end

  assign fin = busy && (rnd == CNT_W'(ROUNDS));
  assign digest = {va + SHA_IV[159:128], vb + SHA_IV[127:96], vc + SHA_IV[95:64],
                   vd + SHA_IV[63:32], ve + SHA_IV[31:0]};

  assert_round_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (rnd <= CNT_W'(ROUNDS)));
  assert_fin_ends_run_R8: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy);

endmodule

// File: rtl/mreg_file.sv
module mreg_file
  import mreg_pkg::*;
#(
  parameter int NREG = 8,
  parameter int NSTAT = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] ridx,
  output logic [DIG_W-1:0] rdata,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [DIG_W-1:0] wdata,
  input  logic             clr,
  input  logic [IDX_W-1:0] cidx
);

  localparam logic [IDX_W-1:0] FIRST_DYN = IDX_W'(NSTAT);

  logic [DIG_W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= (i < NSTAT) ? '0 : '1;
    end else if (we) begin
      mem[widx] <= wdata;
    end else if (clr) begin
      mem[cidx] <= '0;
    end
  end

  assign rdata = mem[ridx];

  assert_clear_dynamic_only_R6: assert property (@(posedge clk) disable iff (rst)
    clr |-> (cidx >= FIRST_DYN));
  assert_single_writer_R2: assert property (@(posedge clk) disable iff (rst)
    !(we && clr));

endmodule

// File: rtl/mreg_bank.sv
module mreg_bank
  import mreg_pkg::*;
#(
  parameter int NREG = 8,
  parameter int NSTAT = 4,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [DIG_W-1:0] cmd_meas,
  output logic             busy,
  output logic             done,
  output logic             rd_valid,
  output logic [DIG_W-1:0] rd_data,
  output logic             err,
  output logic             rej
);

  localparam logic [IDX_W-1:0] FIRST_DYN = IDX_W'(NSTAT);

  op_e              op;
  logic             acc, ext_go, rd_go, clr_go, clr_static;
  logic             fin;
  logic [DIG_W-1:0] digest, cur_val;
  logic [IDX_W-1:0] ext_idx;

  assign op         = op_e'(cmd_op);
  assign acc        = cmd_valid && !busy;
  assign ext_go     = acc && (op == OP_EXTEND);
  assign rd_go      = acc && (op == OP_READ);
  assign clr_go     = acc && (op == OP_CLEAR) && (cmd_idx >= FIRST_DYN);
  assign clr_static = acc && (op == OP_CLEAR) && (cmd_idx < FIRST_DYN);

  mreg_file #(.NREG(NREG), .NSTAT(NSTAT)) u_file (
    .clk(clk), .rst(rst),
    .ridx(cmd_idx), .rdata(cur_val),
    .we(fin), .widx(ext_idx), .wdata(digest),
    .clr(clr_go), .cidx(cmd_idx)
  );

  mreg_sha1 u_sha (
    .clk(clk), .rst(rst), .start(ext_go),
    .chain(cur_val), .meas(cmd_meas),
    .busy(busy), .fin(fin), .digest(digest)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      err      <= 1'b0;
      rej      <= 1'b0;
      ext_idx  <= '0;
    end else begin
      done     <= fin;
      rd_valid <= rd_go;
      err      <= clr_static;
      rej      <= cmd_valid && busy;
      if (rd_go)  rd_data <= cur_val;
      if (ext_go) ext_idx <= cmd_idx;
    end
  end

  assert_static_clear_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 2'b10 && cmd_idx < FIRST_DYN) |=> err);
  assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 2'b01) |=> rd_valid);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_at_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  assert_refuse_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> (rej && !rd_valid && !err));
  assert_noop_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_op == 2'b11) |=> (!rd_valid && !err && !busy));

endmodule

// File: tb/test_mreg_bank.sv
module test_mreg_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'b11;
  logic [2:0]   cmd_idx = '0;
  logic [159:0] cmd_meas = '0;
  logic         busy, done, rd_valid, err, rej;
  logic [159:0] rd_data;

  int total = 0;
  int bad = 0;

  logic [159:0] model [NREG];
  logic [159:0] exp_q [$];
  string        tag_q [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  mreg_bank i_mreg_bank (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_meas(cmd_meas), .busy(busy), .done(done),
    .rd_valid(rd_valid), .rd_data(rd_data), .err(err), .rej(rej)
  );

  function automatic logic [159:0] sha1_ref(input logic [159:0] old, input logic [159:0] m);
    logic [511:0] blk;
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    blk = {old, m, 1'b1, 127'd0, 64'd320};
    for (int i = 0; i < 16; i++) w[i] = blk[511-32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      t = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
      w[i] = {t[30:0], t[31]};
    end
    a = 32'h67452301; b = 32'hEFCDAB89; c = 32'h98BADCFE; d = 32'h10325476; e = 32'hC3D2E1F0;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);         k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                  k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                  k = 32'hCA62C1D6; end
      t = {a[26:0], a[31:27]} + f + e + k + w[i];
      e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
    end
    return {a + 32'h67452301, b + 32'hEFCDAB89, c + 32'h98BADCFE,
            d + 32'h10325476, e + 32'hC3D2E1F0};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [159:0] act, input logic [159:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 unexpected rd_valid", rd_data, '0);
      end else begin
        logic [159:0] ev;
        string tg;
        ev = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk(rd_data === ev, tg, rd_data, ev);
      end
    end
  end

  task automatic send(input logic [1:0] op, input logic [2:0] idx, input logic [159:0] m);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_meas = m;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] idx, input string tag);
    exp_q.push_back(model[idx]);
    tag_q.push_back(tag);
    send(2'b01, idx, '0);
  endtask

  // extend with optional intrusion of refused commands mid-hash
  task automatic do_extend(input logic [2:0] idx, input logic [159:0] m, input bit intrude,
                           input logic [2:0] other);
    logic [159:0] expv;
    int cnt;
    expv = sha1_ref(model[idx], m);
    send(2'b00, idx, m);
    cnt = 0;
    while (busy === 1'b1 && cnt < 200) begin
      cnt++;
      if (intrude) begin
        case (cnt)
          10: begin cmd_valid = 1'b1; cmd_op = 2'b00; cmd_idx = other; cmd_meas = ~m; end
          11: begin
                chk(rej === 1'b1, "R9 extend refused", {159'd0, rej}, 160'd1);
                cmd_op = 2'b01;
              end
          12: begin
                chk(rej === 1'b1 && rd_valid === 1'b0, "R9 read refused",
                    {158'd0, rej, rd_valid}, 160'd2);
                cmd_op = 2'b10;
              end
          13: begin
                chk(rej === 1'b1, "R9 clear refused", {159'd0, rej}, 160'd1);
                cmd_valid = 1'b0;
              end
          default: ;
        endcase
      end
      @(negedge clk);
    end
    chk(cnt == 81, "R8 busy length", 160'(cnt), 160'd81);
    chk(done === 1'b1, "R8 done at idle", {159'd0, done}, 160'd1);
    model[idx] = expv;
    @(negedge clk);
    chk(done === 1'b0, "R8 done one cycle", {159'd0, done}, 160'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    report();
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = (i < 4) ? '0 : '1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, rd_valid, err, rej} === 5'b0, "R8 outputs idle after reset",
        {155'd0, busy, done, rd_valid, err, rej}, '0);
    for (int i = 0; i < 4; i++) do_read(3'(i), "R3 static boot zero");
    for (int i = 4; i < NREG; i++) do_read(3'(i), "R4 dynamic boot ones");

    do_extend(3'd0, 160'h0123456789abcdef_fedcba9876543210_deadbeef, 1'b0, 3'd0);
    do_read(3'd0, "R1 extend static");
    do_extend(3'd0, {5{32'hA5A5_5A5A}}, 1'b0, 3'd0);
    do_read(3'd0, "R10 chained extend");
    do_extend(3'd7, 160'h1, 1'b0, 3'd0);
    do_read(3'd7, "R1 extend dynamic from ones");

    // R9: intrude with extend/read/clear on reg 6 during extend of reg 2
    do_extend(3'd2, {160{1'b1}} ^ 160'h77, 1'b1, 3'd6);
    do_read(3'd2, "R9 running extend unaffected");
    do_read(3'd6, "R9 refused commands left reg untouched");

    // R6: clear on static reg 2 (now non-zero)
    send(2'b10, 3'd2, '0);
    chk(err === 1'b1, "R6 err pulse", {159'd0, err}, 160'd1);
    @(negedge clk);
    chk(err === 1'b0, "R6 err one cycle", {159'd0, err}, 160'd0);
    do_read(3'd2, "R6 static unchanged after clear");

    // R5: clear dynamic reg 7 and 5
    send(2'b10, 3'd7, '0);
    chk(err === 1'b0, "R5 no err on dynamic clear", {159'd0, err}, 160'd0);
    model[7] = '0;
    do_read(3'd7, "R5 dynamic cleared");
    send(2'b10, 3'd5, '0);
    model[5] = '0;
    do_extend(3'd5, 160'h1, 1'b0, 3'd0);
    do_read(3'd5, "R10 extend after clear starts from zero");

    // R2: no-op code 11 carrying data
    do_extend(3'd6, 160'hCAFE, 1'b0, 3'd0);
    send(2'b11, 3'd6, 160'h1234);
    chk({rd_valid, err, busy} === 3'b0, "R2 no-op quiet", {157'd0, rd_valid, err, busy}, '0);
    do_read(3'd6, "R2 no-op left value");
    send(2'b11, 3'd1, '1);
    do_read(3'd1, "R2 no-op static");
    do_read(3'd4, "R7 untouched dynamic");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all reads returned", 160'(exp_q.size()), '0);
    report();
  end

endmodule